// File: doc/BRIEF.md
# Lookup-Cache Maintenance Command Engine

This block takes one seven-word maintenance descriptor at a time over a valid/ready handshake. It decodes the descriptor and works on a small lookup cache. The cache is split into two logical engines, a flow engine and an address engine. Each engine holds `ENTRIES` slots, and each slot keeps a tag, a valid bit, a dirty bit and a saturating statistics counter. The search data path keeps the cache populated through an update port. Every update writes the tag, sets the valid bit, ORs in the dirty flag, and either bumps the counter (same tag already valid) or restarts it at 1.

A 4-bit opcode selects the operation. The engine can report or clear one slot's statistics, or report an address fold without touching the cache. It can write back, invalidate, or write back and invalidate, either for one slot or for the whole cache. Write-back beats go out on a valid/ready port. Each beat carries the slot's tag and a 32-bit payload, which is the counter zero-extended and optionally byte-reversed. Every command ends with exactly one status record, steered to one of two status outputs. The record echoes the 64-bit metadata, the opcode and the set number.

A single-slot command normally finds its slot by comparing the low `TAG_W` address bits with the valid tags, and the lowest matching slot wins. In index mode the low address bits name the slot directly.

Top module: `cache_maint_engine`

## Requirements
- R1: After reset `cmd_ready` is 1, and `wb_valid`, `st0_valid` and `st1_valid` are 0.
- R2: Opcode 0 reports the matched slot's counter in `st_stat` with `st_miss`=0 and changes nothing. If no valid slot of the selected engine holds the tag (address bits TAG_W-1:0), `st_miss`=1.
- R3: When descriptor word 1 bit 15 is 1, the slot is address bits log2(ENTRIES)-1:0 and no tag compare is made. The command hits only if that slot is valid. `st_set` echoes word 1 bits 19:16.
- R4: Opcode 2 on a valid dirty slot emits one beat (`wb_tag` = tag, `wb_data` = counter) and clears the dirty bit. On a clean slot it emits no beat. In both cases the counter is reported.
- R5: Opcode 4 reports the counter, emits no beat and clears the valid bit, so a later lookup misses.
- R6: Opcode 6 emits a beat if the slot is dirty, reports the counter and leaves the slot invalid.
- R7: Opcodes 3 and 7 visit slots 0 to ENTRIES-1 in order. They emit a beat for each valid dirty slot and report the beat count in `st_stat`. Opcode 7 and opcode 5 also invalidate every slot, and opcode 5 emits no beats. A stalled beat holds its valid and tag.
- R8: Opcode 8 reports the counter and then sets it to 0.
- R9: Opcode 1 reports the XOR fold of the 40-bit address into STAT_W bits (bit i goes to bit i mod STAT_W). It emits no beat and changes nothing.
- R10: Opcodes 9 to 15 give a status record with `st_err`=1, emit no beat and change nothing.
- R11: Word 1 bit 12 selects the engine (0 flow, 1 address). A command touches only that engine's slots.
- R12: Word 1 bit 13 selects `st1_valid` (1) or `st0_valid` (0). `st_meta` = {word 3, word 2} and `st_op` = word 1 bits 11:8. A pending record holds until it is accepted.
- R13: When word 1 bit 14 is 1, the four bytes of `wb_data` are reversed.
- R14: `cmd_ready` stays 0 from acceptance until the status record has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Engine idle, descriptor taken |
| cmd_desc | input | 224 | Seven 32-bit words, word n at bits 32n+31:32n; address low in word 0; word 1 holds address 39:32 in 7:0, opcode 11:8, engine 12, ring 13, swap 14, index mode 15, set 19:16; metadata in words 2 and 3 |
| upd_valid | input | 1 | Search path slot update |
| upd_engine | input | 1 | Engine of the update |
| upd_index | input | log2(ENTRIES) | Slot of the update |
| upd_tag | input | TAG_W | Tag written |
| upd_dirty | input | 1 | Mark slot dirty |
| wb_valid | output | 1 | Write-back beat valid |
| wb_ready | input | 1 | Write-back beat accepted |
| wb_engine | output | 1 | Engine of the beat |
| wb_tag | output | TAG_W | Tag of the written-back slot |
| wb_data | output | 32 | Counter payload, optionally byte-reversed |
| st0_valid | output | 1 | Status record on output 0 |
| st0_ready | input | 1 | Output 0 accepts |
| st1_valid | output | 1 | Status record on output 1 |
| st1_ready | input | 1 | Output 1 accepts |
| st_meta | output | 64 | Echoed metadata |
| st_stat | output | STAT_W | Counter, beat count or fold |
| st_err | output | 1 | Reserved opcode |
| st_miss | output | 1 | Single-slot lookup missed |
| st_op | output | 4 | Echoed opcode |
| st_set | output | 4 | Echoed set number |

## Verification
The assertions check the following on every cycle:
- `cmd_ready` never overlaps a beat or a status record.
- At most one status output is valid.
- An error flag appears only with a reserved opcode.
- Stalled beats and pending records hold steady.

The slot-level effects need the directed scenarios to show them. These are dirty and valid clearing, counter values, sweep order and beat count, index addressing, isolation between the engines, and the fact that reserved and hash-only commands leave the cache as it was. The scenarios read that state back through later commands.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
  localparam int WORD_W  = 32;
  localparam int DESC_W  = 7 * WORD_W;
  localparam int ADDR_W  = 40;
  localparam int META_W  = 64;
  localparam int WB_W    = 32;
  localparam int ENGINES = 2;

  typedef enum logic [3:0] {
    OP_RD_STAT  = 4'd0,
    OP_HASH     = 4'd1,
    OP_WB_ONE   = 4'd2,
    OP_WB_ALL   = 4'd3,
    OP_INV_ONE  = 4'd4,
    OP_INV_ALL  = 4'd5,
    OP_WBI_ONE  = 4'd6,
    OP_WBI_ALL  = 4'd7,
    OP_CLR_STAT = 4'd8
  } op_e;

  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_SWEEP, S_BEAT, S_STAT} state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [3:0]        op;
    logic              eng;
    logic              ring;
    logic              swap;
    logic              idx_en;
    logic [3:0]        set;
    logic [META_W-1:0] meta;
  } desc_t;

  typedef struct packed {
    logic rsvd;
    logic hash;
    logic sweep;
    logic wb;
    logic inv;
    logic clr;
  } cls_t;
endpackage

// File: rtl/lcm_desc_decode.sv
module lcm_desc_decode
  import lcm_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output desc_t             fields_o,
  output cls_t              cls_o
);
  logic [WORD_W-1:0] w1;
  logic              unused_bits;

  assign w1 = desc_i[1*WORD_W +: WORD_W];
  assign unused_bits = ^{w1[31:20], desc_i[DESC_W-1:4*WORD_W]};

  always_comb begin
    fields_o.addr   = {w1[7:0], desc_i[0 +: WORD_W]};
    fields_o.op     = w1[11:8];
    fields_o.eng    = w1[12];
    fields_o.ring   = w1[13];
    fields_o.swap   = w1[14];
    fields_o.idx_en = w1[15];
    fields_o.set    = w1[19:16];
    fields_o.meta   = {desc_i[3*WORD_W +: WORD_W], desc_i[2*WORD_W +: WORD_W]};
  end

  always_comb begin
    cls_o.rsvd  = fields_o.op > OP_CLR_STAT;
    cls_o.hash  = fields_o.op == OP_HASH;
    cls_o.sweep = fields_o.op inside {OP_WB_ALL, OP_INV_ALL, OP_WBI_ALL};
    cls_o.wb    = fields_o.op inside {OP_WB_ONE, OP_WB_ALL, OP_WBI_ONE, OP_WBI_ALL};
    cls_o.inv   = fields_o.op inside {OP_INV_ONE, OP_INV_ALL, OP_WBI_ONE, OP_WBI_ALL};
    cls_o.clr   = fields_o.op == OP_CLR_STAT;
  end
endmodule

// File: rtl/lcm_cache_bank.sv
module lcm_cache_bank #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int STAT_W  = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic              upd_dirty,
  input  logic              mnt_en,
  input  logic [IDX_W-1:0]  mnt_idx,
  input  logic              mnt_clr_vld,
  input  logic              mnt_clr_dty,
  input  logic              mnt_clr_stat,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic              rd_dty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [STAT_W-1:0] rd_stat
);
  logic [ENTRIES-1:0] vld_q, vld_d, dty_q, dty_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [TAG_W-1:0]   tag_d  [ENTRIES];
  logic [STAT_W-1:0]  stat_q [ENTRIES];
  logic [STAT_W-1:0]  stat_d [ENTRIES];
  logic               same;

  always_comb begin
    vld_d  = vld_q;
    dty_d  = dty_q;
    tag_d  = tag_q;
    stat_d = stat_q;
    same   = vld_q[upd_idx] && (tag_q[upd_idx] == upd_tag);
    if (upd_en) begin
      tag_d[upd_idx] = upd_tag;
      vld_d[upd_idx] = 1'b1;
      dty_d[upd_idx] = (same && dty_q[upd_idx]) || upd_dirty;
      if (!same)
        stat_d[upd_idx] = STAT_W'(1);
      else if (stat_q[upd_idx] != '1)
        stat_d[upd_idx] = stat_q[upd_idx] + 1'b1;
    end
    if (mnt_en) begin
      if (mnt_clr_vld)  vld_d[mnt_idx]  = 1'b0;
      if (mnt_clr_dty)  dty_d[mnt_idx]  = 1'b0;
      if (mnt_clr_stat) stat_d[mnt_idx] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
    end else begin
      vld_q <= vld_d;
      dty_q <= dty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en || mnt_en) begin
      tag_q  <= tag_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && (tag_q[i] == lk_tag)) begin
        lk_hit  = 1'b1;
        lk_slot = IDX_W'(i);
      end
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_dty  = dty_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_stat = stat_q[rd_idx];
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine
  import lcm_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int STAT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [DESC_W-1:0]          cmd_desc,
  input  logic                       upd_valid,
  input  logic                       upd_engine,
  input  logic [$clog2(ENTRIES)-1:0] upd_index,
  input  logic [TAG_W-1:0]           upd_tag,
  input  logic                       upd_dirty,
  output logic                       wb_valid,
  input  logic                       wb_ready,
  output logic                       wb_engine,
  output logic [TAG_W-1:0]           wb_tag,
  output logic [WB_W-1:0]            wb_data,
  output logic                       st0_valid,
  input  logic                       st0_ready,
  output logic                       st1_valid,
  input  logic                       st1_ready,
  output logic [META_W-1:0]          st_meta,
  output logic [STAT_W-1:0]          st_stat,
  output logic                       st_err,
  output logic                       st_miss,
  output logic [3:0]                 st_op,
  output logic [3:0]                 st_set
);
  localparam int              IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [STAT_W-1:0] fold_addr(input logic [ADDR_W-1:0] a);
    logic [STAT_W-1:0] f;
    f = '0;
    for (int i = 0; i < ADDR_W; i++) f[i % STAT_W] = f[i % STAT_W] ^ a[i];
    return f;
  endfunction

  desc_t             dec, d_q;
  cls_t              cls, c_q;
  state_e            st_q, st_d;
  logic [IDX_W-1:0]  ptr_q, ptr_d, rd_idx;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              miss_q, miss_d, ld;
  logic              mnt_en, clr_vld, clr_dty, clr_stat, hit, cand, st_go;
  logic [WB_W-1:0]   raw;

  logic [ENGINES-1:0] b_hit, b_vld, b_dty;
  logic [IDX_W-1:0]   b_slot [ENGINES];
  logic [TAG_W-1:0]   b_tag  [ENGINES];
  logic [STAT_W-1:0]  b_stat [ENGINES];

  lcm_desc_decode u_dec (.desc_i(cmd_desc), .fields_o(dec), .cls_o(cls));

  for (genvar e = 0; e < ENGINES; e++) begin : g_eng
    lcm_cache_bank #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .STAT_W(STAT_W), .IDX_W(IDX_W)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_en      (upd_valid && (upd_engine == 1'(e))),
      .upd_idx     (upd_index),
      .upd_tag     (upd_tag),
      .upd_dirty   (upd_dirty),
      .mnt_en      (mnt_en && (d_q.eng == 1'(e))),
      .mnt_idx     (rd_idx),
      .mnt_clr_vld (clr_vld),
      .mnt_clr_dty (clr_dty),
      .mnt_clr_stat(clr_stat),
      .lk_tag      (d_q.addr[TAG_W-1:0]),
      .lk_hit      (b_hit[e]),
      .lk_slot     (b_slot[e]),
      .rd_idx      (rd_idx),
      .rd_vld      (b_vld[e]),
      .rd_dty      (b_dty[e]),
      .rd_tag      (b_tag[e]),
      .rd_stat     (b_stat[e])
    );
  end

  // Slot under work: the lookup result while executing, the sweep/beat pointer after.
  always_comb begin
    if (st_q == S_EXEC) rd_idx = d_q.idx_en ? d_q.addr[IDX_W-1:0] : b_slot[d_q.eng];
    else                rd_idx = ptr_q;
  end

  assign hit       = d_q.idx_en ? b_vld[d_q.eng] : b_hit[d_q.eng];
  assign cand      = c_q.wb && b_vld[d_q.eng] && b_dty[d_q.eng];
  assign st_go     = (st_q == S_STAT) && (d_q.ring ? st1_ready : st0_ready);
  assign raw       = WB_W'(b_stat[d_q.eng]);
  assign wb_data   = d_q.swap ? {raw[7:0], raw[15:8], raw[23:16], raw[31:24]} : raw;
  assign wb_tag    = b_tag[d_q.eng];
  assign wb_engine = d_q.eng;
  assign st0_valid = (st_q == S_STAT) && !d_q.ring;
  assign st1_valid = (st_q == S_STAT) && d_q.ring;
  assign st_meta   = d_q.meta;
  assign st_stat   = stat_q;
  assign st_err    = c_q.rsvd;
  assign st_miss   = miss_q;
  assign st_op     = d_q.op;
  assign st_set    = d_q.set;

  always_comb begin
    st_d      = st_q;
    ptr_d     = ptr_q;
    stat_d    = stat_q;
    miss_d    = miss_q;
    ld        = 1'b0;
    mnt_en    = 1'b0;
    clr_vld   = 1'b0;
    clr_dty   = 1'b0;
    clr_stat  = 1'b0;
    wb_valid  = 1'b0;
    cmd_ready = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        cmd_ready = 1'b1;
        if (cmd_valid) begin
          ld     = 1'b1;
          miss_d = 1'b0;
          stat_d = '0;
          st_d   = S_EXEC;
        end
      end
      S_EXEC: begin
        if (c_q.rsvd) begin
          st_d = S_STAT;
        end else if (c_q.hash) begin
          stat_d = fold_addr(d_q.addr);
          st_d   = S_STAT;
        end else if (c_q.sweep) begin
          ptr_d  = '0;
          stat_d = '0;
          st_d   = S_SWEEP;
        end else if (!hit) begin
          miss_d = 1'b1;
          st_d   = S_STAT;
        end else begin
          stat_d = b_stat[d_q.eng];
          ptr_d  = rd_idx;
          if (cand) begin
            st_d = S_BEAT;
          end else begin
            mnt_en   = 1'b1;
            clr_vld  = c_q.inv;
            clr_stat = c_q.clr;
            st_d     = S_STAT;
          end
        end
      end
      S_BEAT: begin
        wb_valid = 1'b1;
        if (wb_ready) begin
          mnt_en  = 1'b1;
          clr_dty = 1'b1;
          clr_vld = c_q.inv;
          st_d    = S_STAT;
        end
      end
      S_SWEEP: begin
        wb_valid = cand;
        if (!cand || wb_ready) begin
          mnt_en  = 1'b1;
          clr_dty = cand;
          clr_vld = c_q.inv;
          if (cand) stat_d = stat_q + 1'b1;
          ptr_d = ptr_q + 1'b1;
          if (ptr_q == LAST) st_d = S_STAT;
        end
      end
      S_STAT: begin
        if (st_go) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ptr_q  <= '0;
      stat_q <= '0;
      miss_q <= 1'b0;
      d_q    <= '0;
      c_q    <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      stat_q <= stat_d;
      miss_q <= miss_d;
      if (ld) begin
        d_q <= dec;
        c_q <= cls;
      end
    end
  end
endmodule

// File: rtl/lcm_engine_checker.sv
module lcm_engine_checker #(
  parameter int TAG_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [TAG_W-1:0] wb_tag,
  input logic             st0_valid,
  input logic             st0_ready,
  input logic             st1_valid,
  input logic [63:0]      st_meta,
  input logic             st_err,
  input logic [3:0]       st_op
);
  assert_idle_exclusive_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && (wb_valid || st0_valid || st1_valid)));

  assert_single_ring_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st0_valid, st1_valid}));

  assert_err_only_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st0_valid || st1_valid) && st_err) |-> (st_op > 4'd8));

  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag)));

  assert_status_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st0_valid && !st0_ready) |=> (st0_valid && $stable(st_meta)));
endmodule

bind cache_maint_engine lcm_engine_checker #(.TAG_W(TAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .wb_valid (wb_valid),
  .wb_ready (wb_ready),
  .wb_tag   (wb_tag),
  .st0_valid(st0_valid),
  .st0_ready(st0_ready),
  .st1_valid(st1_valid),
  .st_meta  (st_meta),
  .st_err   (st_err),
  .st_op    (st_op)
);

// File: tb/sim_cache_maint_engine.sv
`timescale 1ns/1ps
module sim_cache_maint_engine;
  import lcm_pkg::*;
  localparam int ENTRIES = 8;
  localparam int TAG_W   = 20;
  localparam int STAT_W  = 16;
  localparam int IW      = $clog2(ENTRIES);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, cmd_valid, cmd_ready, upd_valid, upd_engine, upd_dirty;
  logic [DESC_W-1:0] cmd_desc;
  logic [IW-1:0]     upd_index;
  logic [TAG_W-1:0]  upd_tag, wb_tag;
  logic              wb_valid, wb_ready, wb_engine;
  logic [31:0]       wb_data;
  logic              st0_valid, st0_ready, st1_valid, st1_ready, st_err, st_miss;
  logic [63:0]       st_meta;
  logic [STAT_W-1:0] st_stat;
  logic [3:0]        st_op, st_set;

  cache_maint_engine #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .STAT_W(STAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_desc(cmd_desc),
    .upd_valid(upd_valid), .upd_engine(upd_engine), .upd_index(upd_index), .upd_tag(upd_tag),
    .upd_dirty(upd_dirty), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_engine(wb_engine),
    .wb_tag(wb_tag), .wb_data(wb_data), .st0_valid(st0_valid), .st0_ready(st0_ready),
    .st1_valid(st1_valid), .st1_ready(st1_ready), .st_meta(st_meta), .st_stat(st_stat),
    .st_err(st_err), .st_miss(st_miss), .st_op(st_op), .st_set(st_set));

  int checks = 0, fails = 0;
  int nb;
  logic [TAG_W-1:0]  btag [8];
  logic [31:0]       bdat [8];
  logic [STAT_W-1:0] r_stat;
  logic              r_err, r_miss, r_ring, got, busy_bad;
  logic [63:0]       r_meta;
  logic [3:0]        r_op, r_set;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic upd(input bit e, input int idx, input logic [TAG_W-1:0] t, input bit d);
    @(negedge clk);
    upd_valid = 1'b1; upd_engine = e; upd_index = IW'(idx); upd_tag = t; upd_dirty = d;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic run(input logic [3:0] op, input bit e, input bit ring, input bit sw, input bit ix,
                     input logic [3:0] set, input logic [39:0] a, input logic [63:0] m, input bit stall);
    @(negedge clk);
    cmd_desc = '0;
    cmd_desc[31:0]   = a[31:0];
    cmd_desc[63:32]  = {12'h0, set, ix, sw, ring, e, op, a[39:32]};
    cmd_desc[95:64]  = m[31:0];
    cmd_desc[127:96] = m[63:32];
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    nb = 0; got = 1'b0; busy_bad = 1'b0;
    for (int c = 0; c < 300 && !got; c++) begin
      wb_ready = stall ? ((c % 2) == 1) : 1'b1;
      if (cmd_ready) busy_bad = 1'b1;
      if (wb_valid && wb_ready) begin
        if (nb < 8) begin btag[nb] = wb_tag; bdat[nb] = wb_data; end
        nb++;
      end
      if (st0_valid || st1_valid) begin
        got = 1'b1; r_ring = st1_valid; r_stat = st_stat; r_err = st_err; r_miss = st_miss;
        r_meta = st_meta; r_op = st_op; r_set = st_set;
      end
      @(negedge clk);
    end
    wb_ready = 1'b1;
    chk(got, "R14", "status record arrived", 64'(got), 64'd1);
    chk(!busy_bad, "R14", "cmd_ready low while busy", 64'(busy_bad), 64'd0);
  endtask

  task automatic rd(input bit e, input logic [TAG_W-1:0] t);
    run(4'd0, e, 1'b0, 1'b0, 1'b0, 4'h0, {20'h0, t}, 64'h0, 1'b0);
  endtask

  task automatic t_reset;
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", 64'(cmd_ready), 64'd1);
    chk(!wb_valid && !st0_valid && !st1_valid, "R1", "outputs idle",
        64'({wb_valid, st0_valid, st1_valid}), 64'd0);
  endtask

  task automatic t_fill;
    upd(1'b0, 0, 20'h00111, 1'b1);
    upd(1'b0, 0, 20'h00111, 1'b1);
    upd(1'b0, 0, 20'h00111, 1'b1);
    upd(1'b0, 2, 20'h00222, 1'b0);
    upd(1'b0, 5, 20'h00555, 1'b1);
    upd(1'b1, 0, 20'h00111, 1'b1);
  endtask

  task automatic t_read;
    run(4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h3, 40'h00_0000_0111, 64'hDEAD_BEEF_0123_4567, 1'b0);
    chk(r_stat == 16'd3 && !r_miss, "R2", "read stats", 64'(r_stat), 64'd3);
    chk(nb == 0, "R2", "no beats on read", 64'(nb), 64'd0);
    chk(r_meta == 64'hDEAD_BEEF_0123_4567 && r_ring == 1'b0 && r_op == 4'd0, "R12", "meta echo ring0",
        r_meta, 64'hDEAD_BEEF_0123_4567);
    run(4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 40'h00_0000_0111, 64'h1111_2222_3333_4444, 1'b0);
    chk(r_ring == 1'b1 && r_meta == 64'h1111_2222_3333_4444, "R12", "ring1 steering", 64'(r_ring), 64'd1);
    chk(r_stat == 16'd1, "R11", "address engine counter", 64'(r_stat), 64'd1);
    rd(1'b0, 20'h00999);
    chk(r_miss == 1'b1, "R2", "miss flag", 64'(r_miss), 64'd1);
  endtask

  task automatic t_index;
    run(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hA, 40'hAB_CDE0_0005, 64'h5, 1'b0);
    chk(!r_miss && r_stat == 16'd1, "R3", "index slot 5", 64'(r_stat), 64'd1);
    chk(r_set == 4'hA, "R3", "set echo", 64'(r_set), 64'hA);
    run(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 40'h00_0000_0003, 64'h6, 1'b0);
    chk(r_miss == 1'b1, "R3", "index slot 3 invalid", 64'(r_miss), 64'd1);
  endtask

  task automatic t_reserved;
    run(4'd11, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h00_0000_0111, 64'h7, 1'b0);
    chk(r_err == 1'b1 && r_op == 4'd11, "R10", "error flag", 64'(r_err), 64'd1);
    chk(nb == 0, "R10", "no beats", 64'(nb), 64'd0);
    rd(1'b0, 20'h00111);
    chk(!r_miss && r_stat == 16'd3, "R10", "cache untouched", 64'(r_stat), 64'd3);
  endtask

  task automatic t_hash;
    run(4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h12_3456_789A, 64'h8, 1'b0);
    chk(r_stat == 16'h4CDE && !r_err, "R9", "address fold", 64'(r_stat), 64'h4CDE);
    chk(nb == 0, "R9", "no beats", 64'(nb), 64'd0);
  endtask

  task automatic t_wb_single;
    run(4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h00_0000_0111, 64'h9, 1'b0);
    chk(nb == 1 && btag[0] == 20'h00111 && bdat[0] == 32'h3, "R4", "single beat", 64'(bdat[0]), 64'h3);
    chk(r_stat == 16'd3, "R4", "stats reported", 64'(r_stat), 64'd3);
    run(4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h00_0000_0111, 64'hA, 1'b0);
    chk(nb == 0 && r_stat == 16'd3, "R4", "clean slot no beat", 64'(nb), 64'd0);
  endtask

  task automatic t_swap;
    upd(1'b0, 0, 20'h00111, 1'b1);
    run(4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 40'h00_0000_0111, 64'hB, 1'b0);
    chk(nb == 1 && bdat[0] == 32'h0400_0000, "R13", "byte reversed payload", 64'(bdat[0]), 64'h0400_0000);
  endtask

  task automatic t_clear;
    run(4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h00_0000_0111, 64'hC, 1'b0);
    chk(r_stat == 16'd4 && nb == 0, "R8", "old counter reported", 64'(r_stat), 64'd4);
    rd(1'b0, 20'h00111);
    chk(!r_miss && r_stat == 16'd0, "R8", "counter cleared", 64'(r_stat), 64'd0);
  endtask

  task automatic t_wbinv_single;
    run(4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h00_0000_0555, 64'hD, 1'b0);
    chk(nb == 1 && btag[0] == 20'h00555 && r_stat == 16'd1, "R6", "beat and stats", 64'(nb), 64'd1);
    rd(1'b0, 20'h00555);
    chk(r_miss == 1'b1, "R6", "slot invalidated", 64'(r_miss), 64'd1);
  endtask

  task automatic t_inval_single;
    run(4'd4, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h00_0000_0222, 64'hE, 1'b0);
    chk(nb == 0 && r_stat == 16'd1, "R5", "stats no beat", 64'(r_stat), 64'd1);
    rd(1'b0, 20'h00222);
    chk(r_miss == 1'b1, "R5", "slot invalidated", 64'(r_miss), 64'd1);
  endtask

  task automatic t_sweeps;
    upd(1'b0, 1, 20'h00101, 1'b1);
    upd(1'b0, 3, 20'h00303, 1'b0);
    upd(1'b0, 6, 20'h00606, 1'b1);
    upd(1'b0, 0, 20'h00111, 1'b1);
    run(4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h0, 64'hF, 1'b1);
    chk(nb == 3 && r_stat == 16'd3, "R7", "beat count", 64'(nb), 64'd3);
    chk(btag[0] == 20'h00111 && btag[1] == 20'h00101 && btag[2] == 20'h00606, "R7", "slot order",
        64'({btag[0], btag[1], btag[2]}), 64'h00111_00101_00606);
    chk(bdat[0] == 32'h1 && bdat[2] == 32'h1, "R7", "sweep payload", 64'(bdat[0]), 64'h1);
    run(4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h0, 64'h10, 1'b0);
    chk(nb == 0 && r_stat == 16'd0, "R7", "second sweep empty", 64'(nb), 64'd0);
    run(4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 40'h0, 64'h11, 1'b0);
    chk(nb == 1 && btag[0] == 20'h00111, "R11", "address engine sweep", 64'(nb), 64'd1);
    rd(1'b1, 20'h00111);
    chk(r_miss == 1'b1, "R7", "write back and invalidate all", 64'(r_miss), 64'd1);
    rd(1'b0, 20'h00303);
    chk(!r_miss && r_stat == 16'd1, "R11", "flow engine untouched", 64'(r_miss), 64'd0);
    run(4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 40'h0, 64'h12, 1'b0);
    chk(nb == 0, "R7", "invalidate all no beats", 64'(nb), 64'd0);
    rd(1'b0, 20'h00303);
    chk(r_miss == 1'b1, "R7", "invalidate all clears", 64'(r_miss), 64'd1);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_desc = '0; upd_valid = 1'b0; upd_engine = 1'b0;
    upd_index = '0; upd_tag = '0; upd_dirty = 1'b0; wb_ready = 1'b1; st0_ready = 1'b1; st1_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_read();
    t_index();
    t_reserved();
    t_hash();
    t_wb_single();
    t_swap();
    t_clear();
    t_wbinv_single();
    t_inval_single();
    t_sweeps();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule